// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit tracks the interrupt sources of a PC-style serial port and turns them into one level-sensitive request line and a 4-bit identification code. There are four sources: character timeout, received data, transmitter holding register empty and modem status change. Each source has its own set and clear pulse inputs, so the surrounding logic (the receive queue, the transmitter and the modem-line watcher) can raise and retire its source in any cycle.

A 4-bit enable value, loaded through a write strobe, masks the sources. Among the sources that are both pending and enabled, a fixed priority picks the one reported in the identification code. An identification-register read strobe lets the unit see software reads. A read made while the transmitter-empty source is the one being reported retires that source. Turning the transmitter-empty enable on while it was off raises that source again. Both the code and the request are registered. They reflect every event one clock after it happens.

Top module: `uart_irq_ident`

## Requirements
- R1: Among enabled pending sources the code is chosen by fixed priority: character timeout 0xC, then received data 0x4, then transmitter empty 0x2, then modem status 0x0.
- R2: `irq` is high exactly when the code differs from 0x1. The code 0x1 means no enabled source is pending.
- R3: Enable bit 0 gates both character timeout and received data. Enable bit 1 gates transmitter empty. Enable bit 3 gates modem status. Bit 2 gates nothing.
- R4: After reset the transmitter-empty source is pending, the enables are 0, the code is 0x1 and `irq` is low.
- R5: A pulse on `id_rd` while the registered code is 0x2 clears the transmitter-empty pending bit. A read under any other code changes nothing.
- R6: Writing the enables with bit 1 set, when bit 1 was clear before, sets the transmitter-empty pending bit. Writing bit 1 when it is already set does not.
- R7: When a set and a clear reach the same source in one cycle, the source ends up pending. The same holds when a set meets the read acknowledge.
- R8: `id_code` and `irq` change on the clock edge after the causing input and never before it.
- R9: A source that is pending while masked stays pending and is reported as soon as its enable is turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_cto | input | 1 | Raise character-timeout source |
| clr_cto | input | 1 | Retire character-timeout source |
| set_rxd | input | 1 | Raise received-data source |
| clr_rxd | input | 1 | Retire received-data source |
| set_thre | input | 1 | Raise transmitter-empty source |
| clr_thre | input | 1 | Retire transmitter-empty source |
| set_msc | input | 1 | Raise modem-status source |
| clr_msc | input | 1 | Retire modem-status source |
| en_we | input | 1 | Load enable value |
| en_wdata | input | 4 | New enable value |
| id_rd | input | 1 | Identification-register read strobe |
| id_code | output | 4 | Registered identification code |
| irq | output | 1 | Registered interrupt request |

## Verification
Wrong internal state shows in different ways. A lost or stuck pending bit is hidden while its source is masked or outranked. It appears in `id_code` one cycle after the stimulus that unmasks it, or after every higher source is cleared. For that reason the stimulus walks each source up and down through the priority order. A wrong enable copy or a missed rising-edge detect on bit 1 shows as a missing 0x2 code in the next cycle. Reads are issued under both the 0x2 code and other codes, so that an acknowledge firing at the wrong time shows up later as a missing 0x2 code.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_cto,
  input  logic       clr_cto,
  input  logic       set_rxd,
  input  logic       clr_rxd,
  input  logic       set_thre,
  input  logic       clr_thre,
  input  logic       set_msc,
  input  logic       clr_msc,
  input  logic       en_we,
  input  logic [3:0] en_wdata,
  input  logic       id_rd,
  output logic [3:0] id_code,
  output logic       irq
);
  localparam logic [3:0] CODE_CTO  = 4'hC;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_MSC  = 4'h0;
  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam int S_MSC = 0, S_THRE = 1, S_RXD = 2, S_CTO = 3;

  logic [3:0] pend_q, en_q, pend_nx, en_nx, set_v, clr_v, code_nx;
  logic       ack, rearm;

  assign set_v = {set_cto, set_rxd, set_thre | rearm, set_msc};
  assign clr_v = {clr_cto, clr_rxd, clr_thre | ack, clr_msc};
  assign ack   = id_rd && (id_code == CODE_THRE);
  assign rearm = en_we && en_wdata[1] && !en_q[1];
  assign en_nx   = en_we ? en_wdata : en_q;
  assign pend_nx = (pend_q & ~clr_v) | set_v;

  always_comb begin
    if (pend_nx[S_CTO] && en_nx[0])       code_nx = CODE_CTO;
    else if (pend_nx[S_RXD] && en_nx[0])  code_nx = CODE_RXD;
    else if (pend_nx[S_THRE] && en_nx[1]) code_nx = CODE_THRE;
    else if (pend_nx[S_MSC] && en_nx[3])  code_nx = CODE_MSC;
    else                                  code_nx = CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 4'b0010;
      en_q    <= 4'h0;
      id_code <= CODE_NONE;
      irq     <= 1'b0;
    end else begin
      pend_q  <= pend_nx;
      en_q    <= en_nx;
      id_code <= code_nx;
      irq     <= (code_nx != CODE_NONE);
    end
  end

  a_r2_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_code != CODE_NONE));

  a_r1_cto_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[S_CTO] && en_q[0]) |-> id_code == CODE_CTO);

  a_r5_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && id_code == CODE_THRE && !set_thre && !rearm) |=> !pend_q[S_THRE]);

  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && en_wdata[1] && !en_q[1]) |=> pend_q[S_THRE]);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cto || set_rxd || set_msc) |=>
      ((pend_q & {$past(set_cto), $past(set_rxd), 1'b0, $past(set_msc)}) ==
       {$past(set_cto), $past(set_rxd), 1'b0, $past(set_msc)}));

  a_r9_masked_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[S_RXD] && !en_q[0] && !clr_rxd) |=> pend_q[S_RXD]);
endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  logic clk = 1'b0, rst_n = 1'b0;
  logic set_cto = 0, clr_cto = 0, set_rxd = 0, clr_rxd = 0;
  logic set_thre = 0, clr_thre = 0, set_msc = 0, clr_msc = 0;
  logic en_we = 0, id_rd = 0;
  logic [3:0] en_wdata = 4'h0;
  logic [3:0] id_code;
  logic irq;

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n),
    .set_cto(set_cto), .clr_cto(clr_cto), .set_rxd(set_rxd), .clr_rxd(clr_rxd),
    .set_thre(set_thre), .clr_thre(clr_thre), .set_msc(set_msc), .clr_msc(clr_msc),
    .en_we(en_we), .en_wdata(en_wdata), .id_rd(id_rd),
    .id_code(id_code), .irq(irq));

  int n_chk = 0, n_bad = 0;
  logic [3:0] q_code[$];
  string      q_tag[$];
  logic [3:0] m_p = 4'b0010, m_en = 4'h0, m_code = 4'h1;

  function automatic logic [3:0] ref_code(input logic [3:0] p, input logic [3:0] e);
    if (p[3] && e[0]) return 4'hC;
    if (p[2] && e[0]) return 4'h4;
    if (p[1] && e[1]) return 4'h2;
    if (p[0] && e[3]) return 4'h0;
    return 4'h1;
  endfunction

  task automatic check(input logic [3:0] act, input logic act_irq,
                       input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp || act_irq !== (exp != 4'h1)) begin
      n_bad++;
      $display("FAIL %s/R2: code=%h irq=%b expected code=%h irq=%b",
               tag, act, act_irq, exp, exp != 4'h1);
    end
  endtask

  // vectors ordered {cto, rxd, thre, msc}
  task automatic step(input logic [3:0] s, input logic [3:0] c, input logic we,
                      input logic [3:0] wd, input logic rd, input string tag);
    logic ack, rearm;
    @(negedge clk);
    {set_cto, set_rxd, set_thre, set_msc} = s;
    {clr_cto, clr_rxd, clr_thre, clr_msc} = c;
    en_we = we; en_wdata = wd; id_rd = rd;
    ack   = rd && (m_code == 4'h2);
    rearm = we && wd[1] && !m_en[1];
    m_p   = (m_p & ~(c | {2'b00, ack, 1'b0})) | s | {2'b00, rearm, 1'b0};
    m_en  = we ? wd : m_en;
    #1 check(id_code, irq, m_code, "R8 early");
    m_code = ref_code(m_p, m_en);
    q_code.push_back(m_code);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_code.size() > 0) check(id_code, irq, q_code.pop_front(), q_tag.pop_front());
  end

  initial begin
    #100000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(id_code, irq, 4'h1, "R4 reset");
    step(4'h0, 4'h0, 1, 4'h0, 1, "R4 masked thre, read ignored");
    step(4'h0, 4'h0, 1, 4'h2, 0, "R3 thre enabled");
    step(4'h0, 4'h0, 0, 4'h0, 1, "R5 read acks thre");
    step(4'h0, 4'h0, 0, 4'h0, 1, "R5 second read");
    step(4'h0, 4'h0, 1, 4'h2, 0, "R6 no rearm when set");
    step(4'h0, 4'h0, 1, 4'h0, 0, "R6 disable");
    step(4'h0, 4'h0, 1, 4'h2, 0, "R6 rearm");
    step(4'b0100, 4'h0, 0, 4'h0, 0, "R3 rxd masked");
    step(4'h0, 4'h0, 1, 4'hB, 0, "R9 rxd surfaces");
    step(4'h0, 4'h0, 0, 4'h0, 1, "R5 read under 0x4 ignored");
    step(4'b1000, 4'h0, 0, 4'h0, 0, "R1 cto top");
    step(4'b0001, 4'h0, 0, 4'h0, 0, "R1 msc under cto");
    step(4'h0, 4'b1000, 0, 4'h0, 0, "R1 rxd next");
    step(4'h0, 4'b0100, 0, 4'h0, 0, "R5 thre survived read");
    step(4'b0010, 4'h0, 0, 4'h0, 1, "R7 set beats ack");
    step(4'h0, 4'b0010, 0, 4'h0, 0, "R1 msc lowest");
    step(4'h0, 4'b0001, 0, 4'h0, 0, "R2 none pending");
    step(4'b1000, 4'b1000, 0, 4'h0, 0, "R7 set beats clear");
    step(4'b0001, 4'b1000, 1, 4'h5, 0, "R3 msc masked by bit 2 only");
    step(4'h0, 4'h0, 1, 4'h8, 0, "R3 msc enabled code 0");
    step(4'b0110, 4'h0, 1, 4'h9, 0, "R1 rxd over msc");
    step(4'h0, 4'h0, 1, 4'h8, 0, "R3 bit 0 off hides rxd");
    step(4'h0, 4'h0, 0, 4'h0, 0, "R8 idle");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule